// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block produces the serial clock and the four active-low device selects for a serial flash port, timed from a faster reference clock. Its settings are a clock divisor, the clock polarity and phase, a select field that is either taken as raw line levels or decoded from an index, and four guard delays. All four guard delays are counted in reference clocks. Data shifting and command sequencing are done elsewhere. The surrounding controller asks for a transfer with a one-cycle start request and ends it with a one-cycle stop request.

All settings are captured into shadow registers only while the global enable is low. Deasserting the enable drops every output to its inactive level in the same cycle and abandons any transfer in progress. The selected pattern of the last transfer is remembered across disables. When the next transfer addresses a different pattern, a device-switch delay is inserted before the select falls.

Within one transfer the sequence is fixed. An optional switch delay comes first. Then the select is asserted and a lead delay runs. Whole serial-clock periods follow. A trail delay runs after the last edge, the select is released, and a deselect gap runs before the block reports idle again.

Top module: `spi_sck_cs_gen`

## Requirements
- R1: During a transfer, consecutive serial-clock edges are exactly div+1 reference clocks apart, where div is the 4-bit divisor (0..15), so one clock period is 2*(div+1) reference clocks.
- R2: The serial clock rests at the polarity bit whenever the block is idle. Every transfer ends with the clock back at that level after an even number of edges.
- R3: From the cycle the select lines go low to the first clock edge is lead+1 reference clocks when the phase bit is 1, and lead+1+(div+1) when the phase bit is 0.
- R4: From the last clock edge to the select lines going high is trail + 2*(div+1) + 3 reference clocks.
- R5: From the select lines going high to idle rising is gap + 2*(div+1) + 1 reference clocks. A start request made while not idle is discarded.
- R6: A start request taken in the idle state asserts the select lines at that same clock edge if the pattern equals the one last used (or none was used since reset). Otherwise it asserts them swap+1 reference clocks later.
- R7: With the decoder bit at 0, the select lines show the 4-bit select field unchanged while a transfer holds the select.
- R8: With the decoder bit at 1, a field value v in 0..3 drives only line v low (bit v of cs_n), and a value of 4 or more drives no line low while the clock still runs. At most one line is ever low in this mode.
- R9: A stop request ends the transfer at the first completed clock period after it is seen. A stop given before the first edge yields exactly one period (two edges).
- R10: While the enable is low, cs_n is 1111, the clock is at the polarity level and idle is 1, in the same cycle the enable falls.
- R11: Settings are captured only on clock edges with the enable low. Changes made while the enable is high have no effect.
- R12: After reset, idle is 1, cs_n is 1111 and the serial clock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; settings load while low |
| cfg_div | input | 4 | Clock divisor, half period = cfg_div+1 reference clocks |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Phase; 0 adds a half period before the first edge |
| cfg_sel | input | 4 | Select field: raw line levels or a line index |
| cfg_dec | input | 1 | 1 = decode cfg_sel as an index |
| dly_lead | input | 8 | Select-low to first edge delay |
| dly_trail | input | 8 | Last edge to select-high delay |
| dly_gap | input | 8 | Deselect time between transfers |
| dly_swap | input | 8 | Extra wait when the device pattern changes |
| start | input | 1 | One-cycle transfer request |
| stop | input | 1 | One-cycle end-of-transfer request |
| sck | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low selects |
| idle | output | 1 | No transfer or guard delay in progress |

## Verification
Two events can coincide in one cycle: the stop request and the end-of-period check that decides whether another period begins. With a divisor of 0 the check falls on the very next reference clock after each return edge. The bench raises stop exactly one cycle after seeing that edge, so both land in the same cycle. It then counts the clock edges to confirm that no extra period was produced. A start request made during the deselect gap is judged by watching that the select lines stay high once the block is idle again.

// File: rtl/spi_sck_cs_gen.sv
module spi_sck_cs_gen #(
  parameter int DIVW = 4,
  parameter int CSN  = 4,
  parameter int DLYW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic [CSN-1:0]  cfg_sel,
  input  logic            cfg_dec,
  input  logic [DLYW-1:0] dly_lead,
  input  logic [DLYW-1:0] dly_trail,
  input  logic [DLYW-1:0] dly_gap,
  input  logic [DLYW-1:0] dly_swap,
  input  logic            start,
  input  logic            stop,
  output logic            sck,
  output logic [CSN-1:0]  cs_n,
  output logic            idle
);
  localparam int CW = DLYW + DIVW + 2;
  localparam logic [2:0] S_IDLE = 3'd0, S_SWAP = 3'd1, S_LEAD = 3'd2,
                         S_RUN  = 3'd3, S_TRAIL = 3'd4, S_GAP = 3'd5;

  logic [DIVW-1:0] div_l;
  logic            cpol_l, cpha_l, dec_l;
  logic [CSN-1:0]  sel_l, last_pat;
  logic [DLYW-1:0] lead_l, trail_l, gap_l, swap_l;
  logic [2:0]      st;
  logic [CW-1:0]   cnt;
  logic [DIVW-1:0] hcnt;
  logic            sck_q, stop_p, last_v;

  logic [DIVW:0]   half;
  logic [CSN-1:0]  dec_pat, pat;
  logic [CW-1:0]   lead_ld, trail_ld, gap_ld;
  logic            stop_any, active;

  for (genvar i = 0; i < CSN; i++) begin : g_dec
    localparam logic [CSN-1:0] IDX = CSN'(i);
    assign dec_pat[i] = (sel_l != IDX);
  end

  assign half     = {1'b0, div_l} + (DIVW+1)'(1);
  assign pat      = dec_l ? dec_pat : sel_l;
  assign lead_ld  = CW'(lead_l) + (cpha_l ? CW'(0) : CW'(half));
  assign trail_ld = CW'(trail_l) + CW'(half) + CW'(2);
  assign gap_ld   = CW'(gap_l) + CW'({half, 1'b0});
  assign stop_any = stop_p | stop;
  assign active   = (st == S_LEAD) || (st == S_RUN) || (st == S_TRAIL);

  assign cs_n = (en && active) ? pat : '1;
  assign sck  = (en && st == S_RUN) ? sck_q : cpol_l;
  assign idle = !en || (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_l <= '0; cpol_l <= 1'b0; cpha_l <= 1'b0; dec_l <= 1'b0; sel_l <= '1;
      lead_l <= '0; trail_l <= '0; gap_l <= '0; swap_l <= '0;
      st <= S_IDLE; cnt <= '0; hcnt <= '0; sck_q <= 1'b0; stop_p <= 1'b0;
      last_pat <= '1; last_v <= 1'b0;
    end else if (!en) begin
      div_l <= cfg_div; cpol_l <= cfg_cpol; cpha_l <= cfg_cpha; dec_l <= cfg_dec;
      sel_l <= cfg_sel; lead_l <= dly_lead; trail_l <= dly_trail;
      gap_l <= dly_gap; swap_l <= dly_swap;
      st <= S_IDLE; cnt <= '0; hcnt <= '0; sck_q <= cfg_cpol; stop_p <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          stop_p <= stop;
          if (last_v && last_pat != pat) begin
            st <= S_SWAP; cnt <= CW'(swap_l);
          end else begin
            st <= S_LEAD; cnt <= lead_ld; last_pat <= pat; last_v <= 1'b1;
          end
        end
        S_SWAP: begin
          stop_p <= stop_any;
          if (cnt == '0) begin
            st <= S_LEAD; cnt <= lead_ld; last_pat <= pat; last_v <= 1'b1;
          end else cnt <= cnt - CW'(1);
        end
        S_LEAD: begin
          stop_p <= stop_any;
          if (cnt == '0) begin
            st <= S_RUN; sck_q <= ~cpol_l; hcnt <= div_l;
          end else cnt <= cnt - CW'(1);
        end
        S_RUN: begin
          stop_p <= stop_any;
          if (hcnt != '0) hcnt <= hcnt - DIVW'(1);
          else if (sck_q != cpol_l) begin
            sck_q <= cpol_l; hcnt <= div_l;
          end else if (stop_any) begin
            st <= S_TRAIL; cnt <= trail_ld; stop_p <= 1'b0;
          end else begin
            sck_q <= ~cpol_l; hcnt <= div_l;
          end
        end
        S_TRAIL: begin
          if (cnt == '0) begin
            st <= S_GAP; cnt <= gap_ld;
          end else cnt <= cnt - CW'(1);
        end
        S_GAP: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_sck_cs_gen_chk.sv
module spi_sck_cs_gen_chk #(
  parameter int DIVW = 4,
  parameter int CSN  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            sck,
  input logic [CSN-1:0]  cs_n,
  input logic            idle,
  input logic [2:0]      st,
  input logic            sck_q,
  input logic            cpol_l,
  input logic            dec_l,
  input logic [DIVW-1:0] div_l
);
  logic            prev_q, run_tog;
  logic [DIVW:0]   since;
  logic            tog;

  assign tog = (sck_q != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0; run_tog <= 1'b0; since <= '0;
    end else begin
      prev_q  <= sck_q;
      since   <= tog ? '0 : since + (DIVW+1)'(1);
      run_tog <= (st == 3'd3) ? (run_tog | tog) : 1'b0;
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (&cs_n) && idle && (sck == cpol_l)); // R10
  AST_IDLE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (&cs_n) && (sck == cpol_l)); // R2
  AST_DEC_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dec_l) |-> ($countones(~cs_n) <= 1)); // R8
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == 3'd3 && tog && run_tog) |-> (since == {1'b0, div_l})); // R1
  AST_RUN_EXIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == 3'd4 && $past(st) == 3'd3) |-> (sck_q == cpol_l)); // R9
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(div_l) && $stable(cpol_l) && $stable(dec_l))); // R11
endmodule

bind spi_sck_cs_gen spi_sck_cs_gen_chk #(.DIVW(DIVW), .CSN(CSN)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sck(sck), .cs_n(cs_n), .idle(idle),
  .st(st), .sck_q(sck_q), .cpol_l(cpol_l), .dec_l(dec_l), .div_l(div_l)
);

// File: tb/spi_sck_cs_gen_tb.sv
module spi_sck_cs_gen_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [3:0] cfg_div = '0, cfg_sel = 4'b1110;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_dec = 1'b0;
  logic [7:0] dly_lead = '0, dly_trail = '0, dly_gap = '0, dly_swap = '0;
  logic start = 1'b0, stop = 1'b0;
  logic sck, idle;
  logic [3:0] cs_n;
  int nchk = 0, nfail = 0;

  always #(PERIOD/2) clk = ~clk;

  spi_sck_cs_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_sel(cfg_sel), .cfg_dec(cfg_dec),
    .dly_lead(dly_lead), .dly_trail(dly_trail), .dly_gap(dly_gap),
    .dly_swap(dly_swap), .start(start), .stop(stop),
    .sck(sck), .cs_n(cs_n), .idle(idle)
  );

  task automatic chk_eq(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setcfg(int dv, bit pol, bit pha, logic [3:0] sel, bit dec,
                        int ld, int tr, int gp, int sw);
    en = 1'b0;
    cfg_div = 4'(dv); cfg_cpol = pol; cfg_cpha = pha; cfg_sel = sel; cfg_dec = dec;
    dly_lead = 8'(ld); dly_trail = 8'(tr); dly_gap = 8'(gp); dly_swap = 8'(sw);
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  // k = 0: stop during the switch/lead phase; k even >= 2: stop after k-th edge
  task automatic xfer(int k, int h, int ld, int tr, int gp, bit pha, bit pol,
                      int fall_exp, output logic [3:0] pat_seen);
    int n = 0, tfall = -1, trise = -1, tidle = -1, tfirst = -1, tlast = -1;
    int ntog = 0, bad = 0;
    logic ps;
    ps = sck;
    pat_seen = 4'hF;
    start = 1'b1;
    while (tidle < 0 && n < 4000) begin
      @(negedge clk);
      n++;
      start = 1'b0;
      stop = 1'b0;
      if (tfall < 0 && cs_n != 4'hF) begin tfall = n; pat_seen = cs_n; end
      if (sck != ps) begin
        if (tlast >= 0 && (n - tlast) != h) bad++;
        if (tfirst < 0) tfirst = n;
        tlast = n; ntog++; ps = sck;
        if (ntog == k) stop = 1'b1;
      end
      if (k == 0 && n == 1) stop = 1'b1;
      if (tfall >= 0 && trise < 0 && cs_n == 4'hF) trise = n;
      if (n > 1 && idle) tidle = n;
    end
    chk_eq("R1 edge spacing mismatches", bad, 0);
    chk_eq("R9 edge count", ntog, (k == 0) ? 2 : k);
    chk_eq("R2 final clock level", int'(sck), int'(pol));
    if (fall_exp >= 0) begin
      chk_eq("R6 select assert cycle", tfall, fall_exp);
      chk_eq("R3 lead to first edge", tfirst - tfall, ld + 1 + (pha ? 0 : h));
      chk_eq("R4 last edge to deselect", trise - tlast, tr + 2*h + 3);
      chk_eq("R5 deselect to idle", tidle - trise, gp + 2*h + 1);
    end else begin
      chk_eq("R8 no line selected", int'(tfall), -1);
    end
  endtask

  initial begin
    #(PERIOD*150000);
    nfail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [3:0] pat;
    int divs[5] = '{0, 1, 2, 5, 15};
    repeat (3) @(negedge clk);
    chk_eq("R12 reset idle", int'(idle), 1);
    chk_eq("R12 reset selects", int'(cs_n), 15);
    chk_eq("R12 reset clock", int'(sck), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (divs[d]) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int pha = 0; pha < 2; pha++) begin
          int dv = divs[d];
          int ld = (dv + pha) % 3, tr = (dv * 7 + pol) % 5, gp = dv % 4;
          setcfg(dv, pol[0], pha[0], 4'b1110, 1'b0, ld, tr, gp, 9);
          xfer(pol ? 4 : 0, dv + 1, ld, tr, gp, pha[0], pol[0], 1, pat);
        end
      end
    end
    // R9: stop lands in the same cycle as the period-end check (div 0)
    setcfg(0, 1'b0, 1'b1, 4'b1110, 1'b0, 0, 0, 0, 0);
    xfer(2, 1, 0, 0, 0, 1'b1, 1'b0, 1, pat);
    xfer(6, 1, 0, 0, 0, 1'b1, 1'b0, 1, pat);

    // R6 / R7: device switch delay and raw select field
    setcfg(1, 1'b0, 1'b1, 4'b1101, 1'b0, 1, 1, 1, 5);
    xfer(0, 2, 1, 1, 1, 1'b1, 1'b0, 7, pat);
    chk_eq("R7 raw select pattern", int'(pat), 13);
    xfer(0, 2, 1, 1, 1, 1'b1, 1'b0, 1, pat);
    chk_eq("R6 same device no switch wait", int'(pat), 13);

    // R8: decoded select field
    setcfg(1, 1'b0, 1'b1, 4'd2, 1'b1, 0, 0, 0, 3);
    xfer(0, 2, 0, 0, 0, 1'b1, 1'b0, 5, pat);
    chk_eq("R8 decoded index 2", int'(pat), 11);
    setcfg(1, 1'b0, 1'b1, 4'd0, 1'b1, 0, 0, 0, 0);
    xfer(0, 2, 0, 0, 0, 1'b1, 1'b0, 2, pat);
    chk_eq("R8 decoded index 0", int'(pat), 14);
    setcfg(1, 1'b0, 1'b1, 4'd6, 1'b1, 0, 0, 0, 0);
    xfer(0, 2, 0, 0, 0, 1'b1, 1'b0, -1, pat);

    // R11: changes while enabled are ignored
    setcfg(1, 1'b0, 1'b1, 4'b1110, 1'b0, 2, 1, 1, 0);
    cfg_div = 4'd6; cfg_cpha = 1'b0; dly_lead = 8'd9; cfg_sel = 4'b0111;
    xfer(4, 2, 2, 1, 1, 1'b1, 1'b0, 2, pat);
    chk_eq("R11 select field held", int'(pat), 14);

    // R10: disable mid-transfer
    setcfg(2, 1'b1, 1'b1, 4'b1110, 1'b0, 0, 0, 0, 0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk_eq("R10 transfer active before disable", int'(cs_n), 14);
    en = 1'b0;
    #1;
    chk_eq("R10 disabled selects", int'(cs_n), 15);
    chk_eq("R10 disabled clock", int'(sck), 1);
    chk_eq("R10 disabled idle", int'(idle), 1);
    @(negedge clk);

    // R5: start during the deselect gap is discarded
    setcfg(0, 1'b0, 1'b1, 4'b1110, 1'b0, 0, 0, 20, 0);
    begin
      int seen_low = 0, guard = 0;
      start = 1'b1; stop = 1'b1;
      @(negedge clk); start = 1'b0; stop = 1'b0;
      while (cs_n != 4'hF && guard < 500) begin @(negedge clk); guard++; end
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!idle && guard < 500) begin @(negedge clk); guard++; end
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (cs_n != 4'hF || !idle) seen_low++;
      end
      chk_eq("R5 start in gap discarded", seen_low, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule